// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a 256-byte serial memory on a two-wire bus. It samples the bus clock and data lines with a much faster system clock. It recognises START and STOP conditions, shifts bits in and out most-significant first, and drives the acknowledge slot. Data bytes from the master are routed to a sixteen-entry write buffer. Bytes that a read requests come straight from the on-chip byte array.

A write sets the word pointer and then streams data bytes. When more than sixteen data bytes arrive, the oldest are overwritten, so only the newest sixteen survive. Each surviving byte keeps the address it arrived at. A STOP that closes a write holding at least one byte starts a timed programming cycle. The buffered bytes are copied into the array at the end of that cycle. While the cycle runs, the block does not answer on the bus.

A random read is an address-only write followed by a repeated START in read direction. The master then clocks out bytes in sequence. To end the read, it leaves the acknowledge slot high and issues a STOP.

The top module's `sda_oe` output means "pull the data line low". The pad and the open-drain wiring sit outside this block.

Top module: `twi_mem_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and it begins a command. A STOP is SDA rising while SCL is high, and it ends one. Bytes clocked without a preceding START are never acknowledged.
- R2: The first byte after a START carries a 7-bit device address in bits 7..1 and a direction bit in bit 0, where 1 means read. The block acknowledges only when bits 7..1 equal DEV_ADDR (default 0x50). On a mismatch it ignores the bus until the next START.
- R3: Incoming bits are taken on the SCL rising edge, most-significant bit first. `sda_oe` changes only while SCL is low, so a transmitted bit is stable over the whole SCL high phase.
- R4: `sda_oe` is low after reset and whenever the block is idle.
- R5: After every byte it receives while addressed (device byte, word address, data byte), the block holds SDA low across the high phase of the ninth clock.
- R6: A read returns the byte at the word pointer and then advances the pointer, wrapping from 255 to 0. A master acknowledge requests the next byte. A master not-acknowledge makes the block release SDA and stay silent until START or STOP.
- R7: Each written data byte is destined for the word pointer's value when it arrived, and the pointer advances modulo 256. Only the last 16 data bytes of a write are kept: once 16 are held, each new byte replaces the oldest.
- R8: A STOP after a write holding at least one data byte starts a programming cycle of PROG_CYCLES system clocks. After that cycle the buffered bytes are copied into the array. A write with no data bytes only sets the pointer and starts no cycle.
- R9: While a programming cycle is in progress, every START, STOP and byte on the bus is ignored and no acknowledge is given.
- R10: A repeated START (no STOP before it) begins a new command and discards data bytes buffered since the previous START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Plain writes of a few bytes followed by sequential reads show that data lands at the right addresses and that the pointer advances. A twenty-byte write separates FIFO overwrite, where the first four addresses keep their old contents, from saturation or wrap within the buffer. A write across address 255 separates modulo-256 wrapping from clamping. A wrong device address, bytes sent without START, and a command issued right after a STOP test acknowledge gating: a write with data must then be refused, and an address-only write must be accepted. A repeated START placed before any STOP shows whether buffered bytes are discarded or committed.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_PROG,
        ST_COMMIT
    } state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    // two synchroniser stages plus one history stage per line
    logic [2:0] scl_d, scl_q;
    logic [2:0] sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[1:0], scl_i};
        sda_d = {sda_q[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign start_evt = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_evt  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/twi_wbuf.sv
module twi_wbuf #(
    parameter int DEPTH = 16,
    parameter int AW    = 8,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          clear,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [AW-1:0] addr_d [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_d [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [IW-1:0] wptr_d, wptr_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        wptr_d = wptr_q;
        cnt_d  = cnt_q;
        if (clear) begin
            wptr_d = '0;
            cnt_d  = '0;
        end else if (push) begin
            addr_d[wptr_q] = push_addr;
            data_d[wptr_q] = push_data;
            wptr_d = (wptr_q == IW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (cnt_q != CW'(DEPTH)) cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            wptr_q <= wptr_d;
            cnt_q  <= cnt_d;
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign count   = cnt_q;
    assign rd_addr = addr_q[rd_idx];
    assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/twi_array.sv
module twi_array #(
    parameter int WORDS = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cell_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cell_q[i] <= '0;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_WORDS   = 256,
    parameter int         BUF_WORDS   = 16,
    parameter int         PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import twi_pkg::*;

    localparam int AW = $clog2(MEM_WORDS);
    localparam int IW = $clog2(BUF_WORDS);
    localparam int CW = $clog2(BUF_WORDS + 1);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        state_e        st;
        state_e        nxt;
        logic [3:0]    bits;
        logic [7:0]    sh;
        logic [AW-1:0] addr;
        logic          oe;
        logic [TW-1:0] tmr;
        logic [CW-1:0] cidx;
    } ctl_t;

    ctl_t q, n;

    logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic          wb_push, wb_clear, mem_we;
    logic [CW-1:0] wb_count;
    logic [AW-1:0] wb_rd_addr;
    logic [7:0]    wb_rd_data, mem_rdata;
    logic          busy, idle_st;

    twi_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_wbuf #(.DEPTH(BUF_WORDS), .AW(AW), .DW(8)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(wb_push), .clear(wb_clear),
        .push_addr(q.addr), .push_data(q.sh), .rd_idx(q.cidx[IW-1:0]),
        .count(wb_count), .rd_addr(wb_rd_addr), .rd_data(wb_rd_data)
    );

    twi_array #(.WORDS(MEM_WORDS), .DW(8)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(wb_rd_addr),
        .wdata(wb_rd_data), .raddr(q.addr), .rdata(mem_rdata)
    );

    always_comb begin
        n        = q;
        wb_push  = 1'b0;
        wb_clear = 1'b0;
        mem_we   = 1'b0;
        if (q.st == ST_PROG) begin
            // bus ignored while the timed cycle runs
            n.tmr = q.tmr + 1'b1;
            if (q.tmr == TW'(PROG_CYCLES - 1)) begin
                n.st   = ST_COMMIT;
                n.cidx = '0;
            end
        end else if (q.st == ST_COMMIT) begin
            if (q.cidx == wb_count) begin
                wb_clear = 1'b1;
                n.st     = ST_IDLE;
            end else begin
                mem_we = 1'b1;
                n.cidx = q.cidx + 1'b1;
            end
        end else if (start_evt) begin
            n.st     = ST_DEV;
            n.bits   = '0;
            n.oe     = 1'b0;
            wb_clear = 1'b1;
        end else if (stop_evt) begin
            n.oe   = 1'b0;
            n.bits = '0;
            n.tmr  = '0;
            n.st   = (wb_count != '0) ? ST_PROG : ST_IDLE;
        end else begin
            case (q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise && q.bits != 4'd8) begin
                        n.sh   = {q.sh[6:0], sda_s};
                        n.bits = q.bits + 1'b1;
                    end
                    if (scl_fall && q.bits == 4'd8) begin
                        n.oe = 1'b1;
                        n.st = ST_ACK;
                        if (q.st == ST_DEV) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                n.nxt = q.sh[0] ? ST_RDATA : ST_WADDR;
                            end else begin
                                n.oe = 1'b0;
                                n.st = ST_IDLE;
                            end
                        end else if (q.st == ST_WADDR) begin
                            n.addr = AW'(q.sh);
                            n.nxt  = ST_WDATA;
                        end else begin
                            wb_push = 1'b1;
                            n.addr  = q.addr + 1'b1;
                            n.nxt   = ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.bits = '0;
                        if (q.nxt == ST_RDATA) begin
                            n.sh   = mem_rdata;
                            n.oe   = ~mem_rdata[7];
                            n.addr = q.addr + 1'b1;
                            n.st   = ST_RDATA;
                        end else begin
                            n.oe = 1'b0;
                            n.st = q.nxt;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd7) begin
                            n.oe = 1'b0;
                            n.st = ST_RACK;
                        end else begin
                            n.sh   = {q.sh[6:0], 1'b0};
                            n.oe   = ~q.sh[6];
                            n.bits = q.bits + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            n.st = ST_IDLE;
                        end else begin
                            n.nxt = ST_RDATA;
                            n.st  = ST_ACK;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: ST_IDLE, bits: '0, sh: '0, addr: '0,
                   oe: 1'b0, tmr: '0, cidx: '0};
        end else begin
            q <= n;
        end
    end

    assign busy    = (q.st == ST_PROG) || (q.st == ST_COMMIT);
    assign idle_st = (q.st == ST_IDLE);
    assign sda_oe  = q.oe;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
    parameter int BUF_WORDS = 16,
    parameter int CW        = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          busy,
    input logic          idle_st,
    input logic [CW-1:0] wb_count,
    input logic          wb_push,
    input logic          wb_clear,
    input logic          stop_evt
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle_st |-> !sda_oe); // R4

    AST_BUF_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_count == CW'(BUF_WORDS) && wb_push && !wb_clear) |=> wb_count == CW'(BUF_WORDS)); // R7

    AST_STOP_TO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !busy && wb_count != '0) |=> busy); // R8

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe); // R9
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.BUF_WORDS(BUF_WORDS), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .busy(busy),
    .idle_st(idle_st), .wb_count(wb_count), .wb_push(wb_push),
    .wb_clear(wb_clear), .stop_evt(stop_evt)
);

// File: tb/twi_mem_slave_bench.sv
`timescale 1ns/1ps
module twi_mem_slave_bench;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] model [256];
    logic [7:0] rbuf [32];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_mem_slave #(.PROG_CYCLES(PROG)) u_twi_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic wt(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic bus_start;
        wt(4); sda_m = 1'b1; wt(4); scl = 1'b1; wt(4); sda_m = 1'b0; wt(4); scl = 1'b0;
    endtask

    task automatic bus_stop;
        wt(4); sda_m = 1'b0; wt(4); scl = 1'b1; wt(4); sda_m = 1'b1; wt(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wt(4); sda_m = b[i]; wt(4); scl = 1'b1; wt(8); scl = 1'b0;
        end
        wt(4); sda_m = 1'b1; wt(4); scl = 1'b1; wt(4);
        ack = ~sda_line;
        wt(4); scl = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        logic a, c;
        logic stable;
        stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(8); scl = 1'b1; wt(1);
            a = sda_line; wt(6);
            c = sda_line; wt(1);
            scl = 1'b0;
            b[i] = a;
            if (a !== c) stable = 1'b0;
        end
        chk("R3 data stable while SCL high", {7'd0, stable}, 8'd1);
        wt(4); sda_m = give_ack ? 1'b0 : 1'b1; wt(4); scl = 1'b1; wt(8); scl = 1'b0;
        wt(4); sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] base);
        logic ack;
        bus_start;
        send_byte(8'hA0, ack); chk("R5 ack device write", {7'd0, ack}, 8'd1);
        send_byte(a, ack);     chk("R5 ack word address", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), ack);
            chk("R5 ack data byte", {7'd0, ack}, 8'd1);
            model[8'(a + 8'(i))] = base + 8'(i);
        end
        bus_stop;
    endtask

    task automatic do_read(input logic [7:0] a, input int n);
        logic ack;
        logic [7:0] b;
        bus_start;
        send_byte(8'hA0, ack); chk("R5 ack device write", {7'd0, ack}, 8'd1);
        send_byte(a, ack);     chk("R5 ack word address", {7'd0, ack}, 8'd1);
        bus_start;
        send_byte(8'hA1, ack); chk("R2 ack device read", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        // R6: after the not-acknowledge the line must stay released
        wt(8); scl = 1'b1; wt(4);
        chk("R6 SDA released after NACK", {7'd0, sda_line}, 8'd1);
        wt(4); scl = 1'b0;
        bus_stop;
    endtask

    task automatic wait_prog;
        wt(PROG + 60);
    endtask

    task automatic t_reset;
        chk("R4 sda_oe low after reset", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic t_no_start;
        logic ack;
        send_byte(8'hA0, ack);
        chk("R1 no ack without START", {7'd0, ack}, 8'd0);
        chk("R4 idle not driving", {7'd0, sda_oe}, 8'd0);
        bus_stop;
    endtask

    task automatic t_wrong_addr;
        logic ack;
        bus_start;
        send_byte(8'h84, ack); chk("R2 no ack wrong address", {7'd0, ack}, 8'd0);
        send_byte(8'h00, ack); chk("R2 ignored after mismatch", {7'd0, ack}, 8'd0);
        bus_stop;
    endtask

    task automatic t_basic;
        logic ack;
        do_write(8'h10, 3, 8'h3C);
        bus_start;
        send_byte(8'hA0, ack); chk("R9 no ack during programming", {7'd0, ack}, 8'd0);
        bus_stop;
        wait_prog;
        do_read(8'h0F, 5);
        for (int i = 0; i < 5; i++) chk("R8 R6 sequential read after commit", rbuf[i], model[8'h0F + i]);
    endtask

    task automatic t_overflow;
        do_write(8'h40, 20, 8'hA0);
        // R7: only the last sixteen bytes survive, at 0x44..0x53
        for (int i = 0; i < 4; i++) model[8'h40 + i] = 8'h00;
        wait_prog;
        do_read(8'h42, 4);
        chk("R7 oldest byte dropped 0x42", rbuf[0], 8'h00);
        chk("R7 oldest byte dropped 0x43", rbuf[1], 8'h00);
        chk("R7 kept byte 0x44", rbuf[2], 8'hA4);
        chk("R7 kept byte 0x45", rbuf[3], 8'hA5);
        do_read(8'h53, 2);
        chk("R7 last byte 0x53", rbuf[0], 8'hB3);
        chk("R7 beyond last 0x54", rbuf[1], 8'h00);
    endtask

    task automatic t_wrap;
        do_write(8'hFE, 3, 8'h11);
        wait_prog;
        do_read(8'hFF, 2);
        chk("R6 read at 0xFF", rbuf[0], 8'h12);
        chk("R6 R7 pointer wraps to 0x00", rbuf[1], 8'h13);
    endtask

    task automatic t_addr_only;
        logic ack;
        do_write(8'h30, 0, 8'h00);
        bus_start;
        send_byte(8'hA0, ack);
        chk("R8 address-only write starts no cycle", {7'd0, ack}, 8'd1);
        bus_stop;
    endtask

    task automatic t_restart;
        logic ack;
        logic [7:0] b;
        bus_start;
        send_byte(8'hA0, ack);
        send_byte(8'h60, ack);
        send_byte(8'h77, ack); chk("R5 ack data before restart", {7'd0, ack}, 8'd1);
        bus_start;
        send_byte(8'hA1, ack); chk("R10 repeated start accepted", {7'd0, ack}, 8'd1);
        read_byte(1'b0, b);
        chk("R10 read continues at 0x61", b, model[8'h61]);
        bus_stop;
        wait_prog;
        do_read(8'h60, 1);
        chk("R10 discarded byte not written", rbuf[0], model[8'h60]);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset;
        t_no_start;
        t_wrong_addr;
        t_basic;
        t_overflow;
        t_wrap;
        t_addr_only;
        t_restart;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule